// File: doc/BRIEF.md
# SMBus Host Transaction Sequencer

This block sits between a host-side request port and a byte-level I2C master engine. A request names one of ten SMBus transaction forms, a 7-bit target address, a command code and the write payload: a byte, a word, or a block of up to `BLK_MAX` bytes. The sequencer turns that request into the ordered series of byte operations the engine understands: start with address and direction, send a byte, receive a byte, master NACK, and stop. It issues these one at a time.

Each operation is held on the op port until the engine reports completion with `op_ready`. For start and send operations, `op_ack` carries the target's acknowledge. Received bytes are packed into a result buffer. When the stop completes, `done` pulses for one cycle. At that point the buffer, the received-byte count and an error flag are valid, and they stay held until the next request is accepted. Bit timing, arbitration, bus timeouts and packet error checking belong to the engine or to other blocks.

Top module: `smb_cmd_seq`

## Requirements
- R1: Quick commands issue only a start and a stop. Kind 0 drives op_byte = {addr, 0} and kind 1 drives {addr, 1}, where bit 0 = 1 means read. Op codes are start=0, send=1, receive=2, nack=3, stop=4.
- R2: Receive-byte (kind 3) issues a read start, one receive, a nack and a stop. The byte lands in rd_data[7:0] and rd_len is 1.
- R3: Send-byte (kind 2) issues a write start, sends the command code and stops. Write-byte (kind 4) sends the code, then req_wdata[7:0], then stops. Neither has a second start.
- R4: Read-byte (kind 5) and read-word (kind 7) issue a write start and send the code. They then issue a repeated start {addr, 1}, one receive per result byte, a nack and a stop.
- R5: Word transfers are little-endian both ways. Write-word (kind 6) sends req_wdata[7:0] before req_wdata[15:8]. Read-word puts the first received byte in rd_data[7:0] and the second in rd_data[15:8].
- R6: Block write (kind 8) sends the code, then a count equal to min(req_wlen, 32), then that many bytes of req_wblk, starting with byte 0 (bits 7:0).
- R7: Block read (kind 9) treats its first received byte as a length and replaces any value above 32 by 0. It then receives exactly that many data bytes into rd_blk, starting at byte 0, and reports the length in rd_len. The length byte itself is not stored.
- R8: An operation's op_valid, op_code and op_byte stay unchanged until the cycle in which op_ready is high. The next operation follows only after that cycle.
- R9: A start or send completed with op_ack low is followed directly by a stop. The transaction then ends with done_err high.
- R10: req_ready is high only when no transaction is in progress. A req_valid seen while busy is ignored and does not change the running sequence.
- R11: After reset, req_ready is 1 and op_valid and done are 0. done is high for exactly the one cycle after the stop's op_ready, and the results stay unchanged until the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 4 | Transaction form, codes 0..9 |
| req_addr | input | 7 | Target address |
| req_cmd | input | 8 | Command code |
| req_wdata | input | 16 | Byte or word write payload |
| req_wlen | input | 8 | Requested block write length |
| req_wblk | input | BLK_MAX*8 | Block write payload, byte 0 in bits 7:0 |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| op_valid | output | 1 | Byte operation pending |
| op_code | output | 3 | Operation code |
| op_byte | output | 8 | Address byte or byte to send |
| op_ready | input | 1 | Engine finished the pending operation |
| op_ack | input | 1 | Target acknowledged (start and send) |
| op_rdata | input | 8 | Byte received (receive operations) |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | Transaction aborted on a target NACK |
| rd_data | output | 16 | First two received bytes |
| rd_len | output | $clog2(BLK_MAX+1) | Count of data bytes received |
| rd_blk | output | BLK_MAX*8 | All received data bytes |

## Verification
A request taken at a rising edge puts the first operation on the op port after that edge. Each op_ready sampled at a rising edge replaces the operation, or raises done, after that same edge. The bench therefore drives and reads only at falling edges: it holds op_ready for one full period and reads the next operation at the following falling edge. During deliberate wait periods of zero to two cycles it confirms that the pending operation has not moved. It reads done, done_err, rd_len and rd_blk at the falling edge where done first appears, then one period later to confirm that the pulse has ended and the results are held.

// File: rtl/smb_seq_pkg.sv
package smb_seq_pkg;

    typedef enum logic [3:0] {
        K_QUICK_WR = 4'd0,
        K_QUICK_RD = 4'd1,
        K_SEND     = 4'd2,
        K_RECV     = 4'd3,
        K_WR_BYTE  = 4'd4,
        K_RD_BYTE  = 4'd5,
        K_WR_WORD  = 4'd6,
        K_RD_WORD  = 4'd7,
        K_WR_BLK   = 4'd8,
        K_RD_BLK   = 4'd9
    } xfer_kind_e;

    typedef enum logic [2:0] {
        OP_START = 3'd0,
        OP_SEND  = 3'd1,
        OP_RECV  = 3'd2,
        OP_NACK  = 3'd3,
        OP_STOP  = 3'd4
    } seq_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START1,
        S_CODE,
        S_COUNT,
        S_WDATA,
        S_START2,
        S_RLEN,
        S_RDATA,
        S_NACK,
        S_STOP
    } seq_state_e;

endpackage

// File: rtl/smb_seq_txbuf.sv
module smb_seq_txbuf #(
    parameter int BLK_MAX = 32,
    localparam int IDX_W = $clog2(BLK_MAX + 1),
    localparam int BUF_W = BLK_MAX * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [BUF_W-1:0] load_bytes,
    input  logic [IDX_W-1:0] sel,
    output logic [7:0]       byte_o
);

    logic [7:0] lane_q [BLK_MAX];

    for (genvar i = 0; i < BLK_MAX; i++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q[i] <= '0;
            end else if (load) begin
                lane_q[i] <= load_bytes[8*i +: 8];
            end
        end
    end

    always_comb begin
        byte_o = '0;
        for (int i = 0; i < BLK_MAX; i++) begin
            if (sel == IDX_W'(i)) begin
                byte_o = lane_q[i];
            end
        end
    end

endmodule

// File: rtl/smb_seq_rxbuf.sv
module smb_seq_rxbuf #(
    parameter int BLK_MAX = 32,
    localparam int IDX_W = $clog2(BLK_MAX + 1),
    localparam int BUF_W = BLK_MAX * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    output logic [BUF_W-1:0] buf_o
);

    for (genvar i = 0; i < BLK_MAX; i++) begin : g_slot
        logic [7:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (clr) begin
                slot_q <= '0;
            end else if (wr && (wr_idx == IDX_W'(i))) begin
                slot_q <= wr_byte;
            end
        end
        assign buf_o[8*i +: 8] = slot_q;
    end

endmodule

// File: rtl/smb_cmd_seq.sv
module smb_cmd_seq
    import smb_seq_pkg::*;
#(
    parameter int BLK_MAX = 32,
    localparam int IDX_W = $clog2(BLK_MAX + 1),
    localparam int BUF_W = BLK_MAX * 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [3:0]       req_kind,
    input  logic [6:0]       req_addr,
    input  logic [7:0]       req_cmd,
    input  logic [15:0]      req_wdata,
    input  logic [7:0]       req_wlen,
    input  logic [BUF_W-1:0] req_wblk,
    output logic             req_ready,
    output logic             op_valid,
    output logic [2:0]       op_code,
    output logic [7:0]       op_byte,
    input  logic             op_ready,
    input  logic             op_ack,
    input  logic [7:0]       op_rdata,
    output logic             done,
    output logic             done_err,
    output logic [15:0]      rd_data,
    output logic [IDX_W-1:0] rd_len,
    output logic [BUF_W-1:0] rd_blk
);

    typedef struct packed {
        seq_state_e       st;
        xfer_kind_e       kind;
        logic [6:0]       addr;
        logic [7:0]       code;
        logic [IDX_W-1:0] tx_idx;
        logic [IDX_W-1:0] cnt;
        logic [IDX_W-1:0] rx_n;
        logic             err;
        logic             done;
    } seq_regs_t;

    seq_regs_t        q, d;
    xfer_kind_e       kind_in;
    seq_op_e          op_sel;
    logic             fire;
    logic             tx_load;
    logic             rx_clr;
    logic             rx_wr;
    logic             rd_first;
    logic [IDX_W-1:0] wlen_cap;
    logic [IDX_W-1:0] rlen_cap;
    logic [7:0]       tx_byte;
    logic [BUF_W-1:0] load_bytes;

    assign kind_in    = xfer_kind_e'(req_kind);
    assign fire       = op_valid && op_ready;
    assign rd_first   = (q.kind == K_QUICK_RD) || (q.kind == K_RECV);
    assign wlen_cap   = (req_wlen > 8'(BLK_MAX)) ? IDX_W'(BLK_MAX) : IDX_W'(req_wlen);
    assign rlen_cap   = (op_rdata > 8'(BLK_MAX)) ? '0 : IDX_W'(op_rdata);
    assign load_bytes = (kind_in == K_WR_BLK) ? req_wblk : BUF_W'(req_wdata);

    smb_seq_txbuf #(.BLK_MAX(BLK_MAX)) u_txbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (tx_load),
        .load_bytes (load_bytes),
        .sel        (q.tx_idx),
        .byte_o     (tx_byte)
    );

    smb_seq_rxbuf #(.BLK_MAX(BLK_MAX)) u_rxbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .wr      (rx_wr),
        .wr_idx  (q.rx_n),
        .wr_byte (op_rdata),
        .buf_o   (rd_blk)
    );

    // operation presented for the current state
    always_comb begin
        op_sel  = OP_STOP;
        op_byte = '0;
        case (q.st)
            S_START1: begin op_sel = OP_START; op_byte = {q.addr, rd_first}; end
            S_START2: begin op_sel = OP_START; op_byte = {q.addr, 1'b1};     end
            S_CODE:   begin op_sel = OP_SEND;  op_byte = q.code;             end
            S_COUNT:  begin op_sel = OP_SEND;  op_byte = 8'(q.cnt);          end
            S_WDATA:  begin op_sel = OP_SEND;  op_byte = tx_byte;            end
            S_RLEN,
            S_RDATA:  op_sel = OP_RECV;
            S_NACK:   op_sel = OP_NACK;
            default:  op_sel = OP_STOP;
        endcase
    end

    assign op_valid  = (q.st != S_IDLE);
    assign op_code   = op_sel;
    assign req_ready = (q.st == S_IDLE);

    // next-state computation
    always_comb begin
        d       = q;
        d.done  = 1'b0;
        tx_load = 1'b0;
        rx_clr  = 1'b0;
        rx_wr   = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (req_valid) begin
                    d.st     = S_START1;
                    d.kind   = kind_in;
                    d.addr   = req_addr;
                    d.code   = req_cmd;
                    d.tx_idx = '0;
                    d.rx_n   = '0;
                    d.err    = 1'b0;
                    tx_load  = 1'b1;
                    rx_clr   = 1'b1;
                    case (kind_in)
                        K_RECV, K_WR_BYTE, K_RD_BYTE: d.cnt = IDX_W'(1);
                        K_WR_WORD, K_RD_WORD:         d.cnt = IDX_W'(2);
                        K_WR_BLK:                     d.cnt = wlen_cap;
                        default:                      d.cnt = '0;
                    endcase
                end
            end
            S_START1: begin
                if (fire) begin
                    if (!op_ack) begin
                        d.err = 1'b1;
                        d.st  = S_STOP;
                    end else begin
                        case (q.kind)
                            K_RECV:                       d.st = S_RDATA;
                            K_SEND, K_WR_BYTE, K_RD_BYTE,
                            K_WR_WORD, K_RD_WORD,
                            K_WR_BLK, K_RD_BLK:           d.st = S_CODE;
                            default:                      d.st = S_STOP;
                        endcase
                    end
                end
            end
            S_CODE: begin
                if (fire) begin
                    if (!op_ack) begin
                        d.err = 1'b1;
                        d.st  = S_STOP;
                    end else begin
                        case (q.kind)
                            K_WR_BYTE, K_WR_WORD:          d.st = S_WDATA;
                            K_WR_BLK:                      d.st = S_COUNT;
                            K_RD_BYTE, K_RD_WORD, K_RD_BLK: d.st = S_START2;
                            default:                       d.st = S_STOP;
                        endcase
                    end
                end
            end
            S_COUNT: begin
                if (fire) begin
                    if (!op_ack) begin
                        d.err = 1'b1;
                        d.st  = S_STOP;
                    end else begin
                        d.st = (q.cnt == '0) ? S_STOP : S_WDATA;
                    end
                end
            end
            S_WDATA: begin
                if (fire) begin
                    if (!op_ack) begin
                        d.err = 1'b1;
                        d.st  = S_STOP;
                    end else begin
                        d.tx_idx = q.tx_idx + 1'b1;
                        if (q.tx_idx + 1'b1 == q.cnt) begin
                            d.st = S_STOP;
                        end
                    end
                end
            end
            S_START2: begin
                if (fire) begin
                    if (!op_ack) begin
                        d.err = 1'b1;
                        d.st  = S_STOP;
                    end else begin
                        d.st = (q.kind == K_RD_BLK) ? S_RLEN : S_RDATA;
                    end
                end
            end
            S_RLEN: begin
                if (fire) begin
                    d.cnt = rlen_cap;
                    d.st  = (rlen_cap == '0) ? S_NACK : S_RDATA;
                end
            end
            S_RDATA: begin
                if (fire) begin
                    rx_wr  = 1'b1;
                    d.rx_n = q.rx_n + 1'b1;
                    if (q.rx_n + 1'b1 == q.cnt) begin
                        d.st = S_NACK;
                    end
                end
            end
            S_NACK: begin
                if (fire) begin
                    d.st = S_STOP;
                end
            end
            S_STOP: begin
                if (fire) begin
                    d.st   = S_IDLE;
                    d.done = 1'b1;
                end
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign done     = q.done;
    assign done_err = q.err;
    assign rd_len   = q.rx_n;
    assign rd_data  = rd_blk[15:0];

endmodule

// File: rtl/smb_cmd_seq_chk.sv
module smb_cmd_seq_chk
    import smb_seq_pkg::*;
#(
    parameter int BLK_MAX = 32,
    localparam int IDX_W = $clog2(BLK_MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             op_valid,
    input logic [2:0]       op_code,
    input logic [7:0]       op_byte,
    input logic             op_ready,
    input logic             op_ack,
    input logic             done,
    input logic [IDX_W-1:0] rd_len
);

    logic fire;
    assign fire = op_valid && op_ready;

    AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !op_ready |=> op_valid && $stable(op_code) && $stable(op_byte)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !op_valid); // R10

    AST_NACK_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        fire && !op_ack && (op_code == OP_START || op_code == OP_SEND)
        |=> op_valid && op_code == OP_STOP); // R9

    AST_MNACK_THEN_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op_code == OP_NACK |=> op_valid && op_code == OP_STOP); // R4

    AST_STOP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fire && op_code == OP_STOP |=> done && req_ready); // R11

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_len <= IDX_W'(BLK_MAX)); // R7

    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |-> op_code <= 3'd4); // R1

endmodule

bind smb_cmd_seq smb_cmd_seq_chk #(.BLK_MAX(BLK_MAX)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_byte   (op_byte),
    .op_ready  (op_ready),
    .op_ack    (op_ack),
    .done      (done),
    .rd_len    (rd_len)
);

// File: tb/smb_cmd_seq_bench.sv
module smb_cmd_seq_bench;
    import smb_seq_pkg::*;

    localparam int BLK_MAX = 32;
    localparam int IDX_W   = 6;
    localparam int BUF_W   = BLK_MAX * 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic [3:0]       req_kind;
    logic [6:0]       req_addr;
    logic [7:0]       req_cmd;
    logic [15:0]      req_wdata;
    logic [7:0]       req_wlen;
    logic [BUF_W-1:0] req_wblk;
    logic             req_ready;
    logic             op_valid;
    logic [2:0]       op_code;
    logic [7:0]       op_byte;
    logic             op_ready;
    logic             op_ack;
    logic [7:0]       op_rdata;
    logic             done;
    logic             done_err;
    logic [15:0]      rd_data;
    logic [IDX_W-1:0] rd_len;
    logic [BUF_W-1:0] rd_blk;

    always #5 clk = ~clk;

    smb_cmd_seq #(.BLK_MAX(BLK_MAX)) u_smb_cmd_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_cmd(req_cmd), .req_wdata(req_wdata),
        .req_wlen(req_wlen), .req_wblk(req_wblk), .req_ready(req_ready),
        .op_valid(op_valid), .op_code(op_code), .op_byte(op_byte),
        .op_ready(op_ready), .op_ack(op_ack), .op_rdata(op_rdata),
        .done(done), .done_err(done_err), .rd_data(rd_data),
        .rd_len(rd_len), .rd_blk(rd_blk)
    );

    typedef struct packed {
        logic [3:0]  kind;
        logic [6:0]  addr;
        logic [7:0]  cmd;
        logic [15:0] wdata;
        logic [7:0]  wlen;
        logic [7:0]  blen;
        logic [7:0]  seed;
        logic [7:0]  nack_at;
        logic [3:0]  tag;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'd0, 7'h21, 8'h00, 16'h0000, 8'd0,  8'd0,  8'h00, 8'hFF, 4'd1}, // R1 quick write
        '{4'd1, 7'h22, 8'h00, 16'h0000, 8'd0,  8'd0,  8'h00, 8'hFF, 4'd1}, // R1 quick read
        '{4'd3, 7'h30, 8'h00, 16'h0000, 8'd0,  8'd0,  8'hA5, 8'hFF, 4'd2}, // R2 receive byte
        '{4'd2, 7'h31, 8'h5C, 16'h0000, 8'd0,  8'd0,  8'h00, 8'hFF, 4'd3}, // R3 send byte
        '{4'd4, 7'h32, 8'h10, 16'h0077, 8'd0,  8'd0,  8'h00, 8'hFF, 4'd3}, // R3 write byte
        '{4'd5, 7'h33, 8'h11, 16'h0000, 8'd0,  8'd0,  8'h3C, 8'hFF, 4'd4}, // R4 read byte
        '{4'd6, 7'h34, 8'h12, 16'hBEEF, 8'd0,  8'd0,  8'h00, 8'hFF, 4'd5}, // R5 write word
        '{4'd7, 7'h35, 8'h13, 16'h0000, 8'd0,  8'd0,  8'h81, 8'hFF, 4'd5}, // R5 read word
        '{4'd8, 7'h36, 8'h14, 16'h0000, 8'd5,  8'd0,  8'h40, 8'hFF, 4'd6}, // R6 block write 5
        '{4'd8, 7'h37, 8'h15, 16'h0000, 8'd40, 8'd0,  8'h90, 8'hFF, 4'd6}, // R6 clamp 40 to 32
        '{4'd8, 7'h38, 8'h16, 16'h0000, 8'd0,  8'd0,  8'h00, 8'hFF, 4'd6}, // R6 empty block
        '{4'd9, 7'h39, 8'h17, 16'h0000, 8'd0,  8'd4,  8'h20, 8'hFF, 4'd7}, // R7 length 4
        '{4'd9, 7'h3A, 8'h18, 16'h0000, 8'd0,  8'd32, 8'h55, 8'hFF, 4'd7}, // R7 length at limit
        '{4'd9, 7'h3B, 8'h19, 16'h0000, 8'd0,  8'd33, 8'h66, 8'hFF, 4'd7}, // R7 length 33 -> 0
        '{4'd9, 7'h3F, 8'h1D, 16'h0000, 8'd0,  8'd0,  8'h11, 8'hFF, 4'd7}, // R7 length 0
        '{4'd6, 7'h3C, 8'h1A, 16'h1234, 8'd0,  8'd0,  8'h00, 8'd2,  4'd9}, // R9 NACK on low byte
        '{4'd5, 7'h3D, 8'h1B, 16'h0000, 8'd0,  8'd0,  8'h07, 8'd0,  4'd9}, // R9 NACK on address
        '{4'd8, 7'h3E, 8'h1C, 16'h0000, 8'd6,  8'd0,  8'hC0, 8'd3,  4'd9}  // R9 NACK on first block byte
    };

    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    int               e_code [48];
    logic [7:0]       e_byte [48];
    int               e_n;
    logic [BUF_W-1:0] e_blk;
    int               e_rxn;
    bit               e_err;
    int               o_code [64];
    logic [7:0]       o_byte [64];
    int               o_n;

    task automatic chk(input bit ok, input string what, input logic [BUF_W-1:0] act,
                       input logic [BUF_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic push(input int c, input logic [7:0] b);
        e_code[e_n] = c;
        e_byte[e_n] = b;
        e_n++;
    endtask

    function automatic logic [7:0] resp(input vec_t v, input int k);
        if (v.kind == 4'd9 && k == 0) return v.blen;
        return v.seed + 8'(k * 29);
    endfunction

    function automatic logic [BUF_W-1:0] make_blk(input vec_t v);
        logic [BUF_W-1:0] b;
        for (int i = 0; i < BLK_MAX; i++) b[8*i +: 8] = v.seed + 8'(i * 3);
        return b;
    endfunction

    task automatic add_recv(input vec_t v, input int k, input int j);
        push(2, 8'h00);
        e_blk[8*j +: 8] = resp(v, k);
        e_rxn++;
    endtask

    task automatic build_exp(input vec_t v);
        logic [BUF_W-1:0] wb;
        int n;
        wb = make_blk(v);
        e_n = 0; e_blk = '0; e_rxn = 0; e_err = 1'b0;
        case (v.kind)
            4'd0: push(0, {v.addr, 1'b0});
            4'd1: push(0, {v.addr, 1'b1});
            4'd2: begin push(0, {v.addr, 1'b0}); push(1, v.cmd); end
            4'd3: begin push(0, {v.addr, 1'b1}); add_recv(v, 0, 0); push(3, 8'h00); end
            4'd4: begin push(0, {v.addr, 1'b0}); push(1, v.cmd); push(1, v.wdata[7:0]); end
            4'd5: begin
                push(0, {v.addr, 1'b0}); push(1, v.cmd); push(0, {v.addr, 1'b1});
                add_recv(v, 0, 0); push(3, 8'h00);
            end
            4'd6: begin
                push(0, {v.addr, 1'b0}); push(1, v.cmd);
                push(1, v.wdata[7:0]); push(1, v.wdata[15:8]);
            end
            4'd7: begin
                push(0, {v.addr, 1'b0}); push(1, v.cmd); push(0, {v.addr, 1'b1});
                add_recv(v, 0, 0); add_recv(v, 1, 1); push(3, 8'h00);
            end
            4'd8: begin
                n = (v.wlen > 8'd32) ? 32 : int'(v.wlen);
                push(0, {v.addr, 1'b0}); push(1, v.cmd); push(1, 8'(n));
                for (int i = 0; i < n; i++) push(1, wb[8*i +: 8]);
            end
            default: begin
                n = (v.blen > 8'd32) ? 0 : int'(v.blen);
                push(0, {v.addr, 1'b0}); push(1, v.cmd); push(0, {v.addr, 1'b1});
                push(2, 8'h00);
                for (int i = 0; i < n; i++) add_recv(v, i + 1, i);
                push(3, 8'h00);
            end
        endcase
        push(4, 8'h00);
        if (int'(v.nack_at) < e_n - 1) begin
            e_n = int'(v.nack_at) + 1;
            push(4, 8'h00);
            e_err = 1'b1;
            e_rxn = 0;
            e_blk = '0;
        end
    endtask

    task automatic run_vec(input vec_t v, input bit poke, input int tag);
        int  krecv;
        int  guard;
        bit  got;
        bit  hold_bad;
        bit  trace_ok;
        logic [2:0] cur_c;
        logic [7:0] cur_b;
        logic       s_err;
        logic [IDX_W-1:0] s_len;
        logic [BUF_W-1:0] s_blk;
        build_exp(v);
        req_kind  = v.kind;
        req_addr  = v.addr;
        req_cmd   = v.cmd;
        req_wdata = v.wdata;
        req_wlen  = v.wlen;
        req_wblk  = make_blk(v);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        o_n = 0; krecv = 0; guard = 0; got = 1'b0; hold_bad = 1'b0;
        s_err = 1'b0; s_len = '0; s_blk = '0;
        while (!got && guard < 400) begin
            guard++;
            if (done) begin
                got = 1'b1;
                s_err = done_err; s_len = rd_len; s_blk = rd_blk;
            end else if (op_valid) begin
                cur_c = op_code;
                cur_b = op_byte;
                if (o_n < 64) begin
                    o_code[o_n] = int'(op_code);
                    o_byte[o_n] = op_byte;
                end
                if (poke && o_n == 0) begin
                    req_valid = 1'b1;
                    req_kind  = 4'd1;
                end
                for (int w = 0; w < o_n % 3; w++) begin
                    @(negedge clk);
                    if (!op_valid || op_code !== cur_c || op_byte !== cur_b) hold_bad = 1'b1;
                end
                op_ready = 1'b1;
                op_ack   = (o_n != int'(v.nack_at));
                op_rdata = (cur_c == 3'd2) ? resp(v, krecv) : 8'h00;
                if (cur_c == 3'd2) krecv++;
                @(negedge clk);
                op_ready  = 1'b0;
                op_ack    = 1'b0;
                op_rdata  = 8'h00;
                req_valid = 1'b0;
                o_n++;
            end else begin
                @(negedge clk);
            end
        end
        trace_ok = got && (o_n == e_n);
        for (int i = 0; i < e_n && i < 64; i++) begin
            if (o_code[i] != e_code[i]) trace_ok = 1'b0;
            if ((e_code[i] <= 1) && (o_byte[i] !== e_byte[i])) trace_ok = 1'b0;
        end
        chk(trace_ok, $sformatf("R%0d op sequence (ops seen %0d)", tag, o_n),
            BUF_W'(o_n), BUF_W'(e_n));
        chk(s_err == e_err, $sformatf("R%0d done_err", tag), BUF_W'(s_err), BUF_W'(e_err));
        chk(int'(s_len) == e_rxn, $sformatf("R%0d rd_len", tag), BUF_W'(s_len), BUF_W'(e_rxn));
        chk(s_blk === e_blk, $sformatf("R%0d received bytes", tag), s_blk, e_blk);
        chk(!hold_bad, "R8 op held until op_ready", BUF_W'(hold_bad), '0);
        @(negedge clk);
        chk(!done && req_ready && rd_len == s_len && rd_blk === s_blk,
            "R11 done is one cycle and results held",
            BUF_W'({done, req_ready}), BUF_W'(2'b01));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R11 watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_kind = '0; req_addr = '0; req_cmd = '0;
        req_wdata = '0; req_wlen = '0; req_wblk = '0;
        op_ready = 1'b0; op_ack = 1'b0; op_rdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(req_ready && !op_valid && !done, "R11 reset state",
            BUF_W'({req_ready, op_valid, done}), BUF_W'(3'b100));

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 1'b0, int'(VECS[i].tag));
        end

        // R10 request raised while busy must not disturb the running word write
        run_vec(VECS[6], 1'b1, 10);
        chk(!op_valid && req_ready, "R10 busy request dropped",
            BUF_W'({op_valid, req_ready}), BUF_W'(2'b01));

        // R2 back-to-back: results of a read cleared by the next accepted request
        run_vec(VECS[2], 1'b0, 2);
        run_vec(VECS[0], 1'b0, 1);
        chk(rd_len == '0 && rd_data == 16'h0000, "R2 buffer cleared on next request",
            BUF_W'({rd_len, rd_data}), '0);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule